// File: doc/BRIEF.md
# PCI Interrupt Slot Router

This block turns a PCI interrupt request into one wire to the processor. A request arrives as a slot number, an interrupt pin (0 stands for INTA and 3 for INTD) and an update strobe. The block maps the pair onto an internal interrupt number, and the mapping rule depends on the slot. It then looks up that number's bit in two 32-bit configuration vectors. One vector selects edge or level behaviour for each line. The other gives the level driven for each line that works in level mode.

Internal numbers begin at a base of 32. Bit k of each vector belongs to internal number 32 + k. A slot outside the routed set keeps its raw pin number. Such a number has no bit in the vectors, so its update leaves the processor interrupt untouched. The mapped number is registered, and it shows on an output in the cycle after the strobe.

Top module: `irq_slot_router`

## Requirements
- R1: While reset is asserted, and right after it, `irqNum` is 0 and `cpuIrq` is 0.
- R2: `irqNum` takes the mapped number at the clock edge where `upd` is high. It keeps that value through every cycle without `upd`.
- R3: Slot 5 maps to 32 + (pin mod 4).
- R4: Slot 6 maps to 36 and slot 7 maps to 37, whatever the pin.
- R5: Slots 8 to 12 map to 38 + (slot − 8) + pin.
- R6: Every other slot maps to the pin number itself, 0 to 3.
- R7: The line's bit index is the mapped number minus 32. When that index lies in 0..31 and its `edgeVec` bit is 1, `cpuIrq` is high for the one cycle after the update. It then returns to 0, unless that next cycle carries another in-range update.
- R8: When the index lies in 0..31 and its `edgeVec` bit is 0, `cpuIrq` takes the line's `polVec` bit after the update. It keeps that value until the next in-range update.
- R9: When the mapped number falls outside 32..63, neither vector is consulted and `cpuIrq` keeps its settled value. A pulse still in progress ends as usual.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| upd | input | 1 | Update strobe for the current request |
| slot | input | 5 | Slot number of the requesting device |
| pin | input | 2 | Interrupt pin, 0 to 3 |
| edgeVec | input | 32 | Per-line mode select: 1 gives a pulse, 0 gives a level |
| polVec | input | 32 | Per-line level used in level mode |
| irqNum | output | 8 | Registered internal interrupt number |
| cpuIrq | output | 1 | Interrupt line to the processor |

## Verification
The block's only internal state is the registered number, the output level and a flag that marks a live pulse. A fault in any of these shows at the ports one cycle after the update that caused it. A stuck pulse flag shows as `cpuIrq` held high one cycle too long. A wrong mapping shows at once as a wrong `irqNum`, or as the wrong vector bit driving `cpuIrq`. Sweeping every slot and pin under several vector patterns puts each case at the ports within two cycles of its update.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

  // Strobes sent from the control block to the datapath.
  typedef struct packed {
    logic capture;   // load the mapped number
    logic drvHigh;   // force the processor line high
    logic drvLow;    // force the processor line low (level mode)
    logic endPulse;  // retire a pulse issued one cycle ago
  } drv_strobe_t;

endpackage

// File: rtl/irq_route_dpath.sv
module irq_route_dpath
  import irq_router_pkg::*;
#(
  parameter int BASE     = 32,
  parameter int VEC_W    = 32,
  parameter int SLOT_W   = 5,
  parameter int PIN_W    = 2,
  parameter int NUM_W    = 8,
  parameter int SB_SLOT  = 5,
  parameter int VID_SLOT = 6,
  parameter int VID_OFS  = 4,
  parameter int NIC_SLOT = 7,
  parameter int NIC_OFS  = 5,
  parameter int EXP_LO   = 8,
  parameter int EXP_HI   = 12,
  parameter int EXP_OFS  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [SLOT_W-1:0] slot,
  input  logic [PIN_W-1:0]  pin,
  input  logic [VEC_W-1:0]  edgeVec,
  input  logic [VEC_W-1:0]  polVec,
  input  drv_strobe_t       strb,
  output logic              lineHit,
  output logic              edgeBit,
  output logic              polBit,
  output logic [NUM_W-1:0]  irqNum,
  output logic              cpuIrq
);

  localparam int IDX_W = (VEC_W > 1) ? $clog2(VEC_W) : 1;

  logic [NUM_W-1:0] mapNum;
  logic [IDX_W-1:0] lineIdx;
  int               slotI;
  int               pinI;

  // Slot-dependent pin routing.
  always_comb begin
    slotI = int'(slot);
    pinI  = int'(pin);
    if (slotI == SB_SLOT)
      mapNum = NUM_W'(BASE + (pinI % 4));
    else if (slotI == VID_SLOT)
      mapNum = NUM_W'(BASE + VID_OFS);
    else if (slotI == NIC_SLOT)
      mapNum = NUM_W'(BASE + NIC_OFS);
    else if (slotI >= EXP_LO && slotI <= EXP_HI)
      mapNum = NUM_W'(BASE + EXP_OFS + (slotI - EXP_LO) + pinI);
    else
      mapNum = NUM_W'(pinI);
  end

  // Vector lookup; a number outside the window touches no bit.
  always_comb begin
    lineHit = (int'(mapNum) >= BASE) && (int'(mapNum) < BASE + VEC_W);
    lineIdx = IDX_W'(int'(mapNum) - BASE);
    edgeBit = lineHit & edgeVec[lineIdx];
    polBit  = lineHit & polVec[lineIdx];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      irqNum <= '0;
    else if (strb.capture)
      irqNum <= mapNum;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      cpuIrq <= 1'b0;
    else if (strb.drvHigh)
      cpuIrq <= 1'b1;
    else if (strb.drvLow | strb.endPulse)
      cpuIrq <= 1'b0;
  end

endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_router_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        upd,
  input  logic        lineHit,
  input  logic        edgeBit,
  input  logic        polBit,
  output drv_strobe_t strb
);

  logic pulseQ;
  logic take;

  always_comb begin
    take          = upd & lineHit;
    strb.capture  = upd;
    strb.drvHigh  = take & (edgeBit | polBit);
    strb.drvLow   = take & ~edgeBit & ~polBit;
    strb.endPulse = pulseQ & ~take;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      pulseQ <= 1'b0;
    else
      pulseQ <= take & edgeBit;
  end

endmodule

// File: rtl/irq_slot_router.sv
module irq_slot_router
  import irq_router_pkg::*;
#(
  parameter int BASE     = 32,
  parameter int VEC_W    = 32,
  parameter int SLOT_W   = 5,
  parameter int PIN_W    = 2,
  parameter int NUM_W    = 8,
  parameter int VID_SLOT = 6,
  parameter int VID_OFS  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              upd,
  input  logic [SLOT_W-1:0] slot,
  input  logic [PIN_W-1:0]  pin,
  input  logic [VEC_W-1:0]  edgeVec,
  input  logic [VEC_W-1:0]  polVec,
  output logic [NUM_W-1:0]  irqNum,
  output logic              cpuIrq
);

  drv_strobe_t strb;
  logic        lineHit;
  logic        edgeBit;
  logic        polBit;

  irq_route_dpath #(
    .BASE(BASE), .VEC_W(VEC_W), .SLOT_W(SLOT_W), .PIN_W(PIN_W),
    .NUM_W(NUM_W), .VID_SLOT(VID_SLOT), .VID_OFS(VID_OFS)
  ) uDpath (
    .clk(clk), .rstN(rstN), .slot(slot), .pin(pin),
    .edgeVec(edgeVec), .polVec(polVec), .strb(strb),
    .lineHit(lineHit), .edgeBit(edgeBit), .polBit(polBit),
    .irqNum(irqNum), .cpuIrq(cpuIrq)
  );

  irq_route_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .upd(upd),
    .lineHit(lineHit), .edgeBit(edgeBit), .polBit(polBit),
    .strb(strb)
  );

endmodule

// File: rtl/irq_slot_router_chk.sv
module irq_slot_router_chk #(
  parameter int BASE     = 32,
  parameter int VEC_W    = 32,
  parameter int SLOT_W   = 5,
  parameter int NUM_W    = 8,
  parameter int VID_SLOT = 6,
  parameter int VID_OFS  = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              upd,
  input logic [SLOT_W-1:0] slot,
  input logic [NUM_W-1:0]  irqNum,
  input logic              cpuIrq,
  input logic              endPulse
);

  a_r2_num_holds: assert property (@(posedge clk) disable iff (!rstN)
    !upd |=> $stable(irqNum));

  a_r4_fixed_slot: assert property (@(posedge clk) disable iff (!rstN)
    (upd && int'(slot) == VID_SLOT) |=> int'(irqNum) == BASE + VID_OFS);

  a_r7_rise_needs_update: assert property (@(posedge clk) disable iff (!rstN)
    !upd |=> !$rose(cpuIrq));

  a_r7_pulse_ends: assert property (@(posedge clk) disable iff (!rstN)
    endPulse |=> !cpuIrq);

  a_r9_outside_holds: assert property (@(posedge clk) disable iff (!rstN)
    (upd && !endPulse) |=>
      ((int'(irqNum) >= BASE && int'(irqNum) < BASE + VEC_W) || $stable(cpuIrq)));

endmodule

bind irq_slot_router irq_slot_router_chk #(
  .BASE(BASE), .VEC_W(VEC_W), .SLOT_W(SLOT_W), .NUM_W(NUM_W),
  .VID_SLOT(VID_SLOT), .VID_OFS(VID_OFS)
) uChk (
  .clk(clk), .rstN(rstN), .upd(upd), .slot(slot),
  .irqNum(irqNum), .cpuIrq(cpuIrq), .endPulse(strb.endPulse)
);

// File: tb/irq_slot_router_test.sv
`timescale 1ns/1ps
module irq_slot_router_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        upd = 1'b0;
  logic [4:0]  slot = '0;
  logic [1:0]  pin = '0;
  logic [31:0] edgeV = '0;
  logic [31:0] polV = '0;
  logic [7:0]  irqNum;
  logic        cpuIrq;

  int checks = 0;
  int fails = 0;
  int mdl = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  irq_slot_router uut (
    .clk(clk), .rstN(rstN), .upd(upd), .slot(slot), .pin(pin),
    .edgeVec(edgeV), .polVec(polV), .irqNum(irqNum), .cpuIrq(cpuIrq)
  );

  function automatic int expNum(int s, int p);
    if (s == 5) return 32 + (p % 4);
    if (s == 6) return 36;
    if (s == 7) return 37;
    if (s >= 8 && s <= 12) return 38 + (s - 8) + p;
    return p;
  endfunction

  function automatic string mapReq(int s);
    if (s == 5) return "R3";
    if (s == 6 || s == 7) return "R4";
    if (s >= 8 && s <= 12) return "R5";
    return "R6";
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doUpd(int s, int p);
    int n, first, settle;
    string cReq;
    @(negedge clk);
    slot = 5'(s); pin = 2'(p); upd = 1'b1;
    @(negedge clk);
    upd = 1'b0;
    n = expNum(s, p);
    if (n >= 32 && n < 64) begin
      if (edgeV[n-32]) begin first = 1; settle = 0; cReq = "R7"; end
      else begin first = int'(polV[n-32]); settle = first; cReq = "R8"; end
    end else begin
      first = mdl; settle = mdl; cReq = "R9";
    end
    chk(mapReq(s), int'(irqNum), n);
    chk(cReq, int'(cpuIrq), first);
    @(negedge clk);
    chk(cReq, int'(cpuIrq), settle);
    chk("R2 hold", int'(irqNum), n);
    mdl = settle;
  endtask

  task automatic sweep(logic [31:0] e, logic [31:0] pv);
    @(negedge clk);
    edgeV = e; polV = pv;
    for (int s = 0; s < 32; s++)
      for (int p = 0; p < 4; p++)
        doUpd(s, p);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=done");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", int'(irqNum), 0);
    chk("R1", int'(cpuIrq), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", int'(irqNum), 0);
    chk("R1", int'(cpuIrq), 0);

    sweep(32'h0000_0000, 32'hA5A5_3C3C);
    sweep(32'h0000_1555, 32'h0000_2AAA);
    sweep(32'hFFFF_FFFF, 32'h0000_0000);
    sweep(32'h0000_0000, 32'hFFFF_FFFF);
    // R9: level high, then a pass-through update with vectors cleared.
    doUpd(6, 0);
    @(negedge clk); polV = '0;
    doUpd(2, 1);
    chk("R9 held high", int'(cpuIrq), 1);
    sweep(32'hC0C0_0F0F, 32'h3C3C_5A5A);

    // R7: back-to-back pulse updates keep the line high, then it falls.
    @(negedge clk);
    edgeV = '1; polV = '0;
    slot = 5'd6; pin = 2'd0; upd = 1'b1;
    @(negedge clk);
    chk("R7 first pulse", int'(cpuIrq), 1);
    chk("R4", int'(irqNum), 36);
    slot = 5'd7;
    @(negedge clk);
    upd = 1'b0;
    chk("R7 second pulse", int'(cpuIrq), 1);
    chk("R4", int'(irqNum), 37);
    @(negedge clk);
    chk("R7 pulse end", int'(cpuIrq), 0);
    repeat (3) begin
      @(negedge clk);
      chk("R2 idle", int'(irqNum), 37);
      chk("R7 idle", int'(cpuIrq), 0);
    end

    finished = 1'b1;
    summary();
  end

endmodule